// File: doc/BRIEF.md
# Two-Knee Luma Soft Limiter

This block limits the amplitude of a 10-bit luma stream before it drives a picture tube. The limiting curve has two independent knees. Below a knee's threshold that knee does nothing. Above it, the knee removes a programmable sixteenth-fraction of the amount by which the input exceeds the threshold. Both knees measure that excess from the original input and not from each other's output. Steep settings can therefore pull the curve down as the input rises, and a result that would go below zero is held at zero. A hard ceiling then caps the result.

Samples arrive with a valid strobe. The limited sample leaves through one output register, together with a delayed copy of the strobe. The thresholds, slopes and ceiling code are static configuration inputs, held by registers elsewhere in the chip.

Top module: `slim_soft_limiter`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next state has `out_valid` = 0 and `out_luma` = 0.
- R2: `out_valid` equals the value `in_valid` had one cycle earlier. `out_luma` takes a new value only one cycle after a cycle in which `in_valid` was high, and otherwise keeps its value.
- R3: An input at or below every knee threshold leaves the output equal to the input, unless the hard ceiling caps it.
- R4: Before the ceiling is applied, the result is in − floor((s0·max(in−t0,0) + s1·max(in−t1,0)) / 16). Knee k takes its threshold tk from bits [9k+8:9k] of `knee_tilt` and its slope sk from bits [4k+3:4k] of `knee_slope`. The floor applies to the sum of both terms.
- R5: Both knees measure their excess from the same input. With the input above both thresholds and s0 + s1 > 16, a larger input gives a smaller output.
- R6: A result from R4 that is below zero is output as 0.
- R7: The hard ceiling is 256 + `ceil_code`, which gives a range of 256 to 511. The output never exceeds it, and a result above it is replaced by it.
- R8: A knee whose slope is 0 has no effect at any input level.
- R9: The output never exceeds the input sample it was computed from.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_luma | input | 10 | Unsigned input luma |
| knee_tilt | input | 18 | Two 9-bit knee thresholds, knee 0 in the low bits |
| knee_slope | input | 8 | Two 4-bit knee slopes, knee 0 in the low bits |
| ceil_code | input | 8 | Hard ceiling minus 256 |
| out_valid | output | 1 | Output sample strobe |
| out_luma | output | 10 | Limited luma |

## Verification
The assertions take the configuration from the cycle in which a sample was accepted. They use `$past` of the thresholds, slopes and ceiling code, so they do not require the configuration to stay fixed. They do assume that `in_valid` is a clean 0 or 1 once reset is released, and that a threshold never exceeds the luma range. The second assumption holds by the port widths. The stimulus changes the configuration only between sweeps, after the strobe has dropped and the last sample has been checked. It then sweeps all 1024 input codes back to back under each setting. The settings cover the flat curve, a single knee, knees in both threshold orders, steep combined slopes and the lowest and a mid-range ceiling.

// File: rtl/slim_pkg.sv
package slim_pkg;
  localparam int SLIM_LUMA_W  = 10;
  localparam int SLIM_TILT_W  = 9;
  localparam int SLIM_SLOPE_W = 4;
  localparam int SLIM_CEIL_W  = 8;
  localparam int SLIM_FRAC_W  = 4;
  localparam int SLIM_N_KNEE  = 2;
endpackage

// File: rtl/slim_knee_term.sv
// One knee: slope times the excess of the input over the threshold.
module slim_knee_term #(
  parameter int LUMA_W  = slim_pkg::SLIM_LUMA_W,
  parameter int TILT_W  = slim_pkg::SLIM_TILT_W,
  parameter int SLOPE_W = slim_pkg::SLIM_SLOPE_W,
  localparam int PROD_W = LUMA_W + SLOPE_W
) (
  input  logic [LUMA_W-1:0]  luma,
  input  logic [TILT_W-1:0]  tilt,
  input  logic [SLOPE_W-1:0] slope,
  output logic [PROD_W-1:0]  term
);
  logic [LUMA_W-1:0] tilt_ext;
  logic [LUMA_W-1:0] excess;

  assign tilt_ext = LUMA_W'(tilt);
  assign excess   = (luma > tilt_ext) ? (luma - tilt_ext) : '0;
  assign term     = PROD_W'(excess) * PROD_W'(slope);
endmodule

// File: rtl/slim_reduce.sv
// Sums all knee terms, drops the fraction once, subtracts from the input,
// and floors at zero.
module slim_reduce #(
  parameter int LUMA_W  = slim_pkg::SLIM_LUMA_W,
  parameter int SLOPE_W = slim_pkg::SLIM_SLOPE_W,
  parameter int FRAC_W  = slim_pkg::SLIM_FRAC_W,
  parameter int N_KNEE  = slim_pkg::SLIM_N_KNEE,
  localparam int PROD_W = LUMA_W + SLOPE_W,
  localparam int SUM_W  = PROD_W + $clog2(N_KNEE)
) (
  input  logic [LUMA_W-1:0]              luma,
  input  logic [N_KNEE-1:0][PROD_W-1:0]  terms,
  output logic [LUMA_W-1:0]              shaped
);
  logic [SUM_W-1:0] acc;
  logic [SUM_W-1:0] cut;
  logic [SUM_W-1:0] luma_ext;

  always_comb begin
    acc = '0;
    for (int k = 0; k < N_KNEE; k++) begin
      acc = acc + SUM_W'(terms[k]);
    end
  end

  assign cut      = acc >> FRAC_W;
  assign luma_ext = SUM_W'(luma);
  assign shaped   = (cut >= luma_ext) ? '0 : LUMA_W'(luma_ext - cut);
endmodule

// File: rtl/slim_clip.sv
// Hard ceiling: the top bit of the ceiling is fixed at one, so it can
// never fall below half of its code range.
module slim_clip #(
  parameter int LUMA_W = slim_pkg::SLIM_LUMA_W,
  parameter int CEIL_W = slim_pkg::SLIM_CEIL_W
) (
  input  logic [LUMA_W-1:0] shaped,
  input  logic [CEIL_W-1:0] ceil_code,
  output logic [LUMA_W-1:0] clipped
);
  logic [LUMA_W-1:0] ceiling;

  assign ceiling = LUMA_W'({1'b1, ceil_code});
  assign clipped = (shaped > ceiling) ? ceiling : shaped;
endmodule

// File: rtl/slim_soft_limiter.sv
module slim_soft_limiter #(
  parameter int LUMA_W  = slim_pkg::SLIM_LUMA_W,
  parameter int TILT_W  = slim_pkg::SLIM_TILT_W,
  parameter int SLOPE_W = slim_pkg::SLIM_SLOPE_W,
  parameter int CEIL_W  = slim_pkg::SLIM_CEIL_W,
  parameter int FRAC_W  = slim_pkg::SLIM_FRAC_W,
  parameter int N_KNEE  = slim_pkg::SLIM_N_KNEE,
  localparam int PROD_W = LUMA_W + SLOPE_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic [LUMA_W-1:0]          in_luma,
  input  logic [N_KNEE*TILT_W-1:0]   knee_tilt,
  input  logic [N_KNEE*SLOPE_W-1:0]  knee_slope,
  input  logic [CEIL_W-1:0]          ceil_code,
  output logic                       out_valid,
  output logic [LUMA_W-1:0]          out_luma
);
  logic [N_KNEE-1:0][PROD_W-1:0] terms;
  logic [LUMA_W-1:0]             shaped;
  logic [LUMA_W-1:0]             clipped;

  for (genvar k = 0; k < N_KNEE; k++) begin : g_knee
    slim_knee_term #(
      .LUMA_W (LUMA_W),
      .TILT_W (TILT_W),
      .SLOPE_W(SLOPE_W)
    ) u_knee (
      .luma (in_luma),
      .tilt (knee_tilt[k*TILT_W +: TILT_W]),
      .slope(knee_slope[k*SLOPE_W +: SLOPE_W]),
      .term (terms[k])
    );
  end

  slim_reduce #(
    .LUMA_W (LUMA_W),
    .SLOPE_W(SLOPE_W),
    .FRAC_W (FRAC_W),
    .N_KNEE (N_KNEE)
  ) u_reduce (
    .luma  (in_luma),
    .terms (terms),
    .shaped(shaped)
  );

  slim_clip #(
    .LUMA_W(LUMA_W),
    .CEIL_W(CEIL_W)
  ) u_clip (
    .shaped   (shaped),
    .ceil_code(ceil_code),
    .clipped  (clipped)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_luma  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_luma <= clipped;
      end
    end
  end

  // Observation helpers for the checks below
  logic [LUMA_W-1:0] ceil_seen;
  logic              knees_quiet;

  assign ceil_seen = LUMA_W'({1'b1, ceil_code});

  always_comb begin
    knees_quiet = 1'b1;
    for (int k = 0; k < N_KNEE; k++) begin
      if ((in_luma > LUMA_W'(knee_tilt[k*TILT_W +: TILT_W])) &&
          (knee_slope[k*SLOPE_W +: SLOPE_W] != '0)) begin
        knees_quiet = 1'b0;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);                                          // R2
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);                                        // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_luma));                                 // R2
  AST_UNITY_BELOW: assert property (@(posedge clk) disable iff (rst)
    (in_valid && knees_quiet && (in_luma <= ceil_seen))
      |=> (out_luma == $past(in_luma)));                              // R3
  AST_CEILING: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_luma <= $past(ceil_seen)));                    // R7
  AST_NO_GAIN: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_luma <= $past(in_luma)));                      // R9
endmodule

// File: tb/slim_soft_limiter_tb_top.sv
`timescale 1ns/1ps
module slim_soft_limiter_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [9:0]  in_luma;
  logic [17:0] knee_tilt;
  logic [7:0]  knee_slope;
  logic [7:0]  ceil_code;
  logic        out_valid;
  logic [9:0]  out_luma;

  int n_cmp = 0;
  int n_bad = 0;
  int got [1024];

  always #4 clk = ~clk;

  slim_soft_limiter dut_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_luma   (in_luma),
    .knee_tilt (knee_tilt),
    .knee_slope(knee_slope),
    .ceil_code (ceil_code),
    .out_valid (out_valid),
    .out_luma  (out_luma)
  );

  function automatic int expect_out(int x, int t0, int s0, int t1, int s1, int c);
    int e0, e1, r, lim;
    e0 = (x > t0) ? x - t0 : 0;
    e1 = (x > t1) ? x - t1 : 0;
    r = x - ((s0 * e0 + s1 * e1) / 16);
    if (r < 0) r = 0;
    lim = 256 + c;
    if (r > lim) r = lim;
    return r;
  endfunction

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic sweep(string tag, int t0, int s0, int t1, int s1, int c);
    @(negedge clk);
    knee_tilt  = {9'(t1), 9'(t0)};
    knee_slope = {4'(s1), 4'(s0)};
    ceil_code  = 8'(c);
    for (int x = 0; x <= 1024; x++) begin
      @(negedge clk);
      if (x > 0) begin
        check("R2 out_valid", int'(out_valid), 1);
        check(tag, int'(out_luma), expect_out(x - 1, t0, s0, t1, s1, c));
        check("R9 no gain", int'(out_luma) <= x - 1 ? 1 : 0, 1);
        got[x - 1] = int'(out_luma);
      end
      if (x < 1024) begin
        in_valid = 1'b1;
        in_luma  = 10'(x);
      end else begin
        in_valid = 1'b0;
      end
    end
  endtask

  initial begin
    #(8 * 150000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int held;
    rst        = 1'b1;
    in_valid   = 1'b1;
    in_luma    = 10'd500;
    knee_tilt  = '0;
    knee_slope = '0;
    ceil_code  = 8'd255;
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", int'(out_valid), 0);
    check("R1 out_luma in reset", int'(out_luma), 0);
    in_valid = 1'b0;
    rst = 1'b0;

    // R8 R3: both slopes zero, curve is identity up to ceiling 511
    sweep("R8 R3 flat", 0, 0, 0, 0, 255);
    check("R3 passthrough 300", got[300], 300);
    check("R7 capped at 511", got[1000], 511);

    // R4: single knee, second knee parked
    sweep("R4 single knee", 100, 8, 511, 0, 255);

    // R2: idle strobe keeps the output
    held = got[1023];
    for (int i = 0; i < 4; i++) begin
      in_luma = 10'(37 * i + 5);
      @(negedge clk);
      check("R2 idle out_valid", int'(out_valid), 0);
      check("R2 idle hold", int'(out_luma), held);
    end

    // R5 R6: steep combined slopes go negative, then clamp
    sweep("R5 R6 steep", 200, 15, 300, 15, 255);
    check("R5 falling 350->400", (got[400] < got[350]) ? 1 : 0, 1);
    check("R5 value 400", got[400], 119);
    check("R6 clamp 700", got[700], 0);

    sweep("R6 R4 zero tilts", 0, 15, 0, 15, 255);
    check("R6 clamp 1023", got[1023], 0);

    // R7: lowest ceiling
    sweep("R7 ceiling 256", 511, 4, 511, 12, 0);
    check("R7 cap 800", got[800], 256);

    // R4: knees in reversed threshold order, mid ceiling
    sweep("R4 R7 reversed", 300, 6, 150, 9, 100);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule